// File: doc/BRIEF.md
# Precision Time-of-Day Clock with Event Timestamping

This block keeps network time as two 32-bit words: whole seconds and nanoseconds within the second. On every system clock cycle it adds a programmable nanosecond step to the time. When the nanoseconds word reaches one billion, it wraps to the leftover amount and the seconds word goes up by one. A configuration write port lets software stage a starting time and commit both words together. The same port sets the per-cycle step, a target time and an interrupt enable.

Two capture channels record the current time when an event strobe arrives. One strobe marks the instant a transmit start-of-frame delimiter leaves the media-independent interface. The other marks the end of a received frame. Each captured value is held until the consumer acknowledges it. A capture that arrives before then is dropped and reported through a sticky overrun bit.

The block also drives a pulse-per-second output, which goes high at each seconds rollover. A target comparator raises a sticky flag once time reaches a programmed point, and an enable gates that flag onto an interrupt line.

Top module: `ptp_time_clock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the time words, the pulse output, the target flag, the interrupt, and every capture valid and overrun output are zero. The step register returns to DEF_INC (5).
- R2: Without a load, each clock edge adds the step to the nanoseconds word. The nanoseconds word never reaches 1,000,000,000.
- R3: When nanoseconds plus step is 1,000,000,000 or more, the new nanoseconds value is the sum minus 1,000,000,000, and the seconds word increases by exactly one in that same edge.
- R4: Writing any data to address 5 copies the staged seconds (address 0) and staged nanoseconds (address 1) into the time at the next edge, both words together. No step is added at that edge.
- R5: `pps_out` goes high in the cycle where the seconds word is first seen incremented by a step wrap. It stays high for PPS_CYCLES (8) cycles, and a further wrap restarts that count.
- R6: Writing the target nanoseconds word (address 4) arms the comparator and clears `tgt_flag`. The target seconds word is at address 3. At the first edge where an armed comparator sees current time at or above the target, `tgt_flag` is set. It then stays set until the next write to address 4.
- R7: `tgt_irq` is `tgt_flag` gated by bit 0 of the enable register at address 6.
- R8: A `tx_sfd_stb` in a cycle records the time shown in that cycle onto `tx_ts_sec`/`tx_ts_ns` and sets `tx_ts_valid` at the next edge. The valid and the value then hold until `tx_ts_rd`.
- R9: `rx_done_stb` and `rx_ts_rd` act the same way on the receive capture outputs.
- R10: A strobe that arrives while its channel is valid and not being read leaves the held value unchanged and sets the channel's overrun bit. A read clears both valid and overrun. A strobe in the same cycle as a read captures the new time.
- R11: A write to address 2 sets the step, which takes effect from the following edge. The edge that performs the write still uses the old step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| tx_sfd_stb | input | 1 | Transmit start-of-frame delimiter leaving the interface |
| tx_ts_rd | input | 1 | Acknowledge of the transmit capture |
| rx_done_stb | input | 1 | Received frame complete |
| rx_ts_rd | input | 1 | Acknowledge of the receive capture |
| now_sec | output | 32 | Current seconds |
| now_ns | output | 32 | Current nanoseconds |
| pps_out | output | 1 | Pulse-per-second output |
| tgt_flag | output | 1 | Target time reached, sticky |
| tgt_irq | output | 1 | Enabled target interrupt |
| tx_ts_sec | output | 32 | Captured transmit seconds |
| tx_ts_ns | output | 32 | Captured transmit nanoseconds |
| tx_ts_valid | output | 1 | Transmit capture held and unread |
| tx_ts_ovr | output | 1 | Transmit capture overrun, sticky |
| rx_ts_sec | output | 32 | Captured receive seconds |
| rx_ts_ns | output | 32 | Captured receive nanoseconds |
| rx_ts_valid | output | 1 | Receive capture held and unread |
| rx_ts_ovr | output | 1 | Receive capture overrun, sticky |

## Verification
A wrong carry or an off-by-one step shows up on `now_ns`/`now_sec` at the very next edge. Because the reference model runs in lockstep, that cycle is where the mismatch is reported. A corrupt pulse counter or a comparator armed at the wrong time shows up on `pps_out` or `tgt_flag` within one cycle of the wrap or target crossing. Capture faults show up as a valid or overrun bit that differs from the model in the cycle after the strobe or read, or as a held value that drifts while the channel is unread.

// File: rtl/ptp_tc_pkg.sv
// Shared constants and types of the precision time clock.
// Assumes: nanoseconds are counted modulo one billion.
package ptp_tc_pkg;
    localparam logic [32:0] NS_PER_SEC = 33'd1_000_000_000;

    typedef struct packed {
        logic [31:0] sec;
        logic [31:0] ns;
    } ptp_time_t;

    typedef enum logic [2:0] {
        A_STAGE_SEC = 3'd0,
        A_STAGE_NS  = 3'd1,
        A_STEP      = 3'd2,
        A_TGT_SEC   = 3'd3,
        A_TGT_NS    = 3'd4,
        A_COMMIT    = 3'd5,
        A_IRQ_EN    = 3'd6
    } cfg_addr_e;
endpackage

// File: rtl/ptp_time_counter.sv
// Seconds/nanoseconds time base. Adds step_i each cycle, wraps
// nanoseconds at one billion with the remainder carried, and loads a full
// time atomically on load_i. Assumes step_i < 1e9 and the loaded ns < 1e9.
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  ptp_time_t         load_time_i,
    input  logic [STEP_W-1:0] step_i,
    output ptp_time_t         time_o,
    output logic              roll_o
);
    ptp_time_t   time_q;
    logic [32:0] sum;
    logic        wrap;

    // Next nanoseconds sum and wrap decision.
    always_comb begin
        sum  = {1'b0, time_q.ns} + {{(33-STEP_W){1'b0}}, step_i};
        wrap = (sum >= NS_PER_SEC);
    end

    // Advance or load the time registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (load_i) begin
            time_q <= load_time_i;
        end else begin
            time_q.ns  <= wrap ? 32'(sum - NS_PER_SEC) : sum[31:0];
            time_q.sec <= time_q.sec + {31'd0, wrap};
        end
    end

    assign roll_o = wrap && !load_i;
    assign time_o = time_q;

    AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ({1'b0, time_q.ns} < NS_PER_SEC));                       // R2
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (time_q.sec == $past(time_q.sec)) ||
                    (time_q.sec == $past(time_q.sec) + 32'd1));              // R3
    AST_LOAD_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (time_q == $past(load_time_i)));                          // R4
endmodule

// File: rtl/ptp_pps_gen.sv
// Pulse-per-second generator: output high for PPS_CYCLES cycles starting
// with the cycle the new second is visible. Assumes roll_i is one cycle wide.
module ptp_pps_gen #(
    parameter int PPS_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic roll_i,
    output logic pps_o
);
    localparam int CW = $clog2(PPS_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    // Reload on rollover, otherwise count the pulse down.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (roll_i)        cnt_q <= CW'(PPS_CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign pps_o = (cnt_q != '0);

    AST_PPS_AFTER_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        roll_i |=> pps_o);                                                   // R5
endmodule

// File: rtl/ptp_target_cmp.sv
// Target comparator: once armed, sets a sticky flag the first time the
// current time is at or above the target. Arming clears the flag.
// Assumes target words are stable while armed except through arm_i.
module ptp_target_cmp
    import ptp_tc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm_i,
    input  ptp_time_t time_i,
    input  ptp_time_t target_i,
    output logic      flag_o
);
    logic armed_q;
    logic flag_q;
    logic reached;

    // Lexicographic compare: seconds in the upper half.
    assign reached = (time_i >= target_i);

    // Arm, detect and hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            flag_q  <= 1'b0;
        end else if (arm_i) begin
            armed_q <= 1'b1;
            flag_q  <= 1'b0;
        end else if (armed_q && reached) begin
            armed_q <= 1'b0;
            flag_q  <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !arm_i |=> flag_q);                                        // R6
endmodule

// File: rtl/ptp_ts_capture.sv
// One timestamp capture channel: records time on a strobe, holds it until
// read, and flags strobes lost while unread. Assumes strobes are one cycle.
module ptp_ts_capture
    import ptp_tc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb_i,
    input  logic      rd_i,
    input  ptp_time_t time_i,
    output ptp_time_t ts_o,
    output logic      valid_o,
    output logic      ovr_o
);
    ptp_time_t ts_q;
    logic      valid_q;
    logic      ovr_q;

    // Capture, hold, overrun and read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q    <= '0;
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (stb_i && (!valid_q || rd_i)) begin
            ts_q    <= time_i;
            valid_q <= 1'b1;
            ovr_q   <= 1'b0;
        end else if (rd_i) begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (stb_i) begin
            ovr_q   <= 1'b1;
        end
    end

    assign ts_o    = ts_q;
    assign valid_o = valid_q;
    assign ovr_o   = ovr_q;

    AST_TS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !rd_i |=> $stable(ts_q) && valid_q);                      // R10
    AST_STB_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> valid_q);                                                  // R8
    AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> valid_q);                                                  // R10
endmodule

// File: rtl/ptp_time_clock.sv
// Top of the precision time clock: configuration registers, time base,
// pulse-per-second, target interrupt and two capture channels
// (index 0 transmit SFD, index 1 receive complete). Assumes one clock domain.
module ptp_time_clock
    import ptp_tc_pkg::*;
#(
    parameter int STEP_W     = 8,
    parameter int DEF_INC    = 5,
    parameter int PPS_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        tx_sfd_stb,
    input  logic        tx_ts_rd,
    input  logic        rx_done_stb,
    input  logic        rx_ts_rd,
    output logic [31:0] now_sec,
    output logic [31:0] now_ns,
    output logic        pps_out,
    output logic        tgt_flag,
    output logic        tgt_irq,
    output logic [31:0] tx_ts_sec,
    output logic [31:0] tx_ts_ns,
    output logic        tx_ts_valid,
    output logic        tx_ts_ovr,
    output logic [31:0] rx_ts_sec,
    output logic [31:0] rx_ts_ns,
    output logic        rx_ts_valid,
    output logic        rx_ts_ovr
);
    localparam int NCH = 2;

    ptp_time_t         stage_q;
    ptp_time_t         target_q;
    logic [STEP_W-1:0] step_q;
    logic              irq_en_q;
    ptp_time_t         cur_time;
    logic              roll;
    logic              commit;
    logic              arm;
    logic              flag;

    logic [NCH-1:0]    ch_stb;
    logic [NCH-1:0]    ch_rd;
    logic [NCH-1:0]    ch_valid;
    logic [NCH-1:0]    ch_ovr;
    ptp_time_t         ch_ts [NCH];

    // Decode the single-cycle command strobes.
    always_comb begin
        commit = cfg_we && (cfg_addr == A_COMMIT);
        arm    = cfg_we && (cfg_addr == A_TGT_NS);
    end

    // Configuration register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            target_q <= '0;
            step_q   <= STEP_W'(DEF_INC);
            irq_en_q <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_STAGE_SEC: stage_q.sec  <= cfg_wdata;
                A_STAGE_NS:  stage_q.ns   <= cfg_wdata;
                A_STEP:      step_q       <= cfg_wdata[STEP_W-1:0];
                A_TGT_SEC:   target_q.sec <= cfg_wdata;
                A_TGT_NS:    target_q.ns  <= cfg_wdata;
                A_IRQ_EN:    irq_en_q     <= cfg_wdata[0];
                default:     ;
            endcase
        end
    end

    ptp_time_counter #(.STEP_W(STEP_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (commit),
        .load_time_i (stage_q),
        .step_i      (step_q),
        .time_o      (cur_time),
        .roll_o      (roll)
    );

    ptp_pps_gen #(.PPS_CYCLES(PPS_CYCLES)) u_pps (
        .clk    (clk),
        .rst_n  (rst_n),
        .roll_i (roll),
        .pps_o  (pps_out)
    );

    ptp_target_cmp u_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .time_i   (cur_time),
        .target_i (target_q),
        .flag_o   (flag)
    );

    assign ch_stb = {rx_done_stb, tx_sfd_stb};
    assign ch_rd  = {rx_ts_rd, tx_ts_rd};

    for (genvar g = 0; g < NCH; g++) begin : g_cap
        ptp_ts_capture u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb_i   (ch_stb[g]),
            .rd_i    (ch_rd[g]),
            .time_i  (cur_time),
            .ts_o    (ch_ts[g]),
            .valid_o (ch_valid[g]),
            .ovr_o   (ch_ovr[g])
        );
    end

    assign now_sec     = cur_time.sec;
    assign now_ns      = cur_time.ns;
    assign tgt_flag    = flag;
    assign tgt_irq     = flag && irq_en_q;
    assign tx_ts_sec   = ch_ts[0].sec;
    assign tx_ts_ns    = ch_ts[0].ns;
    assign tx_ts_valid = ch_valid[0];
    assign tx_ts_ovr   = ch_ovr[0];
    assign rx_ts_sec   = ch_ts[1].sec;
    assign rx_ts_ns    = ch_ts[1].ns;
    assign rx_ts_valid = ch_valid[1];
    assign rx_ts_ovr   = ch_ovr[1];

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_irq |-> tgt_flag);                                               // R7
endmodule

// File: tb/tb_ptp_time_clock.sv
module tb_ptp_time_clock;
    localparam int CLK_PERIOD = 10;
    localparam int PPS_CYC    = 8;
    localparam longint unsigned BILLION = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        tx_sfd_stb = 1'b0, tx_ts_rd = 1'b0;
    logic        rx_done_stb = 1'b0, rx_ts_rd = 1'b0;
    logic [31:0] now_sec, now_ns, tx_ts_sec, tx_ts_ns, rx_ts_sec, rx_ts_ns;
    logic        pps_out, tgt_flag, tgt_irq;
    logic        tx_ts_valid, tx_ts_ovr, rx_ts_valid, rx_ts_ovr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    ptp_time_clock #(.STEP_W(8), .DEF_INC(5), .PPS_CYCLES(PPS_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_sfd_stb(tx_sfd_stb), .tx_ts_rd(tx_ts_rd),
        .rx_done_stb(rx_done_stb), .rx_ts_rd(rx_ts_rd), .now_sec(now_sec),
        .now_ns(now_ns), .pps_out(pps_out), .tgt_flag(tgt_flag),
        .tgt_irq(tgt_irq), .tx_ts_sec(tx_ts_sec), .tx_ts_ns(tx_ts_ns),
        .tx_ts_valid(tx_ts_valid), .tx_ts_ovr(tx_ts_ovr),
        .rx_ts_sec(rx_ts_sec), .rx_ts_ns(rx_ts_ns),
        .rx_ts_valid(rx_ts_valid), .rx_ts_ovr(rx_ts_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model state
    longint unsigned m_sec, m_ns, m_inc, m_ssec, m_sns, m_tsec, m_tns;
    int  m_pps;
    bit  m_armed, m_flag, m_en;
    longint unsigned m_cap_sec [2];
    longint unsigned m_cap_ns  [2];
    bit  m_val [2];
    bit  m_ovr [2];

    always @(posedge clk) begin
        longint unsigned sum;
        bit wrap, reached, load;
        bit stb [2];
        bit rd  [2];
        if (!rst_n) begin
            m_sec = 0; m_ns = 0; m_inc = 5; m_ssec = 0; m_sns = 0;
            m_tsec = 0; m_tns = 0; m_pps = 0; m_armed = 0; m_flag = 0; m_en = 0;
            for (int i = 0; i < 2; i++) begin
                m_cap_sec[i] = 0; m_cap_ns[i] = 0; m_val[i] = 0; m_ovr[i] = 0;
            end
        end else begin
            load = cfg_we && cfg_addr == 3'd5;
            sum  = m_ns + m_inc;
            wrap = sum >= BILLION;
            reached = (m_sec > m_tsec) || (m_sec == m_tsec && m_ns >= m_tns);
            if (!load && wrap) m_pps = PPS_CYC;
            else if (m_pps > 0) m_pps = m_pps - 1;
            if (cfg_we && cfg_addr == 3'd4) begin
                m_armed = 1; m_flag = 0;
            end else if (m_armed && reached) begin
                m_armed = 0; m_flag = 1;
            end
            stb[0] = tx_sfd_stb; stb[1] = rx_done_stb;
            rd[0] = tx_ts_rd; rd[1] = rx_ts_rd;
            for (int i = 0; i < 2; i++) begin
                if (stb[i] && (!m_val[i] || rd[i])) begin
                    m_cap_sec[i] = m_sec; m_cap_ns[i] = m_ns; m_val[i] = 1; m_ovr[i] = 0;
                end else if (rd[i]) begin
                    m_val[i] = 0; m_ovr[i] = 0;
                end else if (stb[i]) m_ovr[i] = 1;
            end
            if (load) begin
                m_sec = m_ssec; m_ns = m_sns;
            end else begin
                m_ns  = wrap ? sum - BILLION : sum;
                m_sec = (m_sec + (wrap ? 1 : 0)) & 64'hFFFF_FFFF;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_ssec = cfg_wdata;
                    3'd1: m_sns  = cfg_wdata;
                    3'd2: m_inc  = cfg_wdata[7:0];
                    3'd3: m_tsec = cfg_wdata;
                    3'd4: m_tns  = cfg_wdata;
                    3'd6: m_en   = cfg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Lockstep comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("R2 now_ns", now_ns, m_ns);
            chk("R3 now_sec", now_sec, m_sec);
            chk("R5 pps_out", pps_out, m_pps > 0);
            chk("R6 tgt_flag", tgt_flag, m_flag);
            chk("R7 tgt_irq", tgt_irq, m_flag && m_en);
            chk("R8 tx_valid", tx_ts_valid, m_val[0]);
            chk("R8 tx_sec", tx_ts_sec, m_cap_sec[0]);
            chk("R8 tx_ns", tx_ts_ns, m_cap_ns[0]);
            chk("R9 rx_valid", rx_ts_valid, m_val[1]);
            chk("R9 rx_sec", rx_ts_sec, m_cap_sec[1]);
            chk("R9 rx_ns", rx_ts_ns, m_cap_ns[1]);
            chk("R10 tx_ovr", tx_ts_ovr, m_ovr[0]);
            chk("R10 rx_ovr", rx_ts_ovr, m_ovr[1]);
        end
        if (cycles > 100000 && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        longint unsigned ns0;
        idle(2);
        // R1: reset state
        chk("R1 sec", now_sec, 0);
        chk("R1 ns", now_ns, 0);
        chk("R1 pps", pps_out, 0);
        chk("R1 flag/irq", {tgt_flag, tgt_irq}, 0);
        chk("R1 valid/ovr", {tx_ts_valid, tx_ts_ovr, rx_ts_valid, rx_ts_ovr}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 default step", now_ns, 5);
        idle(10);
        // R8 / R9 / R10 capture patterns
        tx_sfd_stb = 1; @(negedge clk); tx_sfd_stb = 0;
        idle(3);
        rx_done_stb = 1; @(negedge clk); rx_done_stb = 0;
        idle(2);
        tx_sfd_stb = 1; @(negedge clk); tx_sfd_stb = 0;   // overrun on tx
        chk("R10 tx overrun set", tx_ts_ovr, 1);
        idle(2);
        tx_ts_rd = 1; @(negedge clk); tx_ts_rd = 0;
        chk("R10 read clears", {tx_ts_valid, tx_ts_ovr}, 0);
        rx_ts_rd = 1; rx_done_stb = 1; @(negedge clk); rx_ts_rd = 0; rx_done_stb = 0;
        chk("R10 read+strobe recaptures", rx_ts_valid, 1);
        idle(2);
        // R11: step change
        wr(3'd2, 32'd7);
        ns0 = now_ns;
        @(negedge clk);
        chk("R11 new step", now_ns, ns0 + 7);
        // R4: atomic load
        wr(3'd0, 32'd10);
        wr(3'd1, 32'd999_999_990);
        wr(3'd5, 32'd0);
        chk("R4 load sec", now_sec, 10);
        chk("R4 load ns", now_ns, 999_999_990);
        tx_sfd_stb = 1; @(negedge clk); tx_sfd_stb = 0;
        chk("R8 capture before wrap", tx_ts_ns, 999_999_990);
        @(negedge clk);
        // R3: carry of remainder
        chk("R3 sec after wrap", now_sec, 11);
        chk("R3 ns remainder", now_ns, 4);
        chk("R5 pps high", pps_out, 1);
        idle(PPS_CYC);
        chk("R5 pps low after width", pps_out, 0);
        // R6 / R7: target reached, masked then enabled
        wr(3'd3, 32'd11);
        wr(3'd4, 32'd200);
        idle(40);
        chk("R6 flag set", tgt_flag, 1);
        chk("R7 irq masked", tgt_irq, 0);
        wr(3'd6, 32'd1);
        chk("R7 irq enabled", tgt_irq, 1);
        wr(3'd4, 32'd300_000_000);
        chk("R6 rearm clears", tgt_flag, 0);
        idle(10);
        chk("R6 not reached yet", tgt_flag, 0);
        // R3: exact landing on one billion
        wr(3'd1, 32'd999_999_993);
        wr(3'd5, 32'd0);
        rx_ts_rd = 1; @(negedge clk); rx_ts_rd = 0;
        chk("R3 exact wrap sec", now_sec, 11);
        chk("R3 exact wrap ns", now_ns, 0);
        idle(20);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule